// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block answers a set-vector-length request for a vector engine. A request carries the number of elements the application still has to process, an element-width selector, a register-grouping selector and two policy bits (tail agnostic, mask agnostic). From a fixed register width parameter the unit derives how many elements one instruction may cover under that width and grouping. It grants the smaller of that limit and the request, and it latches the new settings as the active configuration.

Unsupported width or grouping codes are refused: the unit raises an illegal flag, grants zero elements and keeps the configuration it held before. The result appears one clock after the request, marked by a one-cycle done pulse, and stays on the outputs until the next request. A combinational side port tells whether a vector register number may serve as the base of an operand group under the active grouping. Group bases must be multiples of the group size.

Top module: `vl_cfg_unit`

## Requirements
- R1: For a legal setting the per-instruction element limit is (VLEN / element width) x group size; vlmax_o shows this limit for the active configuration at all times.
- R2: The granted length vl_o is the request avl_i when avl_i is below the limit, and the limit otherwise; a request of 0 grants 0.
- R3: Width code sew_sel_i 0, 1, 2, 3 selects 8, 16, 32, 64 bits and grouping code lmul_sel_i 0, 1, 2, 3 selects 1, 2, 4, 8 registers; any code 4 to 7 in either field is illegal and gives illegal_o = 1 and vl_o = 0.
- R4: An illegal request leaves cur_sew_o, cur_lmul_o, cur_tail_agn_o, cur_mask_agn_o and vlmax_o unchanged.
- R5: A legal request stores its width code, grouping code, tail-agnostic and mask-agnostic bits as the active configuration and clears illegal_o.
- R6: done_o is high for exactly the one cycle after each cycle in which req_i is high. vl_o and illegal_o change only on that edge and hold until the next request.
- R7: reg_ok_o is 1 exactly when reg_idx_i (0 to 31) is a multiple of the active group size, so groups of 4 allow 0, 4, ..., 28 and groups of 8 allow 0, 8, 16, 24.
- R8: After reset done_o, illegal_o and vl_o are 0, the configuration is width code 0, grouping code 0, both policy bits 0, and vlmax_o is VLEN / 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one cycle per request |
| avl_i | input | AVL_W | Requested element count |
| sew_sel_i | input | 3 | Element width code |
| lmul_sel_i | input | 3 | Register grouping code |
| tail_agn_i | input | 1 | Tail-agnostic policy bit |
| mask_agn_i | input | 1 | Mask-agnostic policy bit |
| reg_idx_i | input | REG_W | Vector register number to test |
| done_o | output | 1 | Result valid pulse |
| illegal_o | output | 1 | Last request was refused |
| vl_o | output | VL_W | Granted element count |
| vlmax_o | output | VL_W | Element limit of the active configuration |
| cur_sew_o | output | 3 | Active width code |
| cur_lmul_o | output | 3 | Active grouping code |
| cur_tail_agn_o | output | 1 | Active tail-agnostic bit |
| cur_mask_agn_o | output | 1 | Active mask-agnostic bit |
| reg_ok_o | output | 1 | reg_idx_i is a legal group base |

## Verification
A wrong configuration register shows at once on the cur_* outputs and vlmax_o. It also shows in the same cycle on reg_ok_o for misaligned register numbers. A wrong limit or clamp shows in vl_o on the edge after the request. The sweep covers every width and grouping code with requests at zero, one, just below, at and above the limit, and at the largest request. Because the configuration is re-read after every request, corruption by a refused request is visible one cycle after that request, before the next one arrives.

// File: rtl/vl_cfg_pkg.sv
package vl_cfg_pkg;
  localparam int unsigned SEL_W        = 3;
  localparam int unsigned SEW_SEL_MAX  = 3;  // e64
  localparam int unsigned LMUL_SEL_MAX = 3;  // x8 group
  localparam int unsigned LMUL_IDX_W   = 2;
  localparam int unsigned MIN_SEW_BITS = 8;

  typedef struct packed {
    logic [SEL_W-1:0] sew;
    logic [SEL_W-1:0] lmul;
    logic             tail_agn;
    logic             mask_agn;
  } vcfg_t;
endpackage

// File: rtl/vl_cfg_decode.sv
module vl_cfg_decode
  import vl_cfg_pkg::*;
(
  input  logic [SEL_W-1:0] sew_sel_i,
  input  logic [SEL_W-1:0] lmul_sel_i,
  output logic             legal_o
);
  logic sew_ok, lmul_ok;
  assign sew_ok  = (sew_sel_i  <= SEL_W'(SEW_SEL_MAX));
  assign lmul_ok = (lmul_sel_i <= SEL_W'(LMUL_SEL_MAX));
  assign legal_o = sew_ok & lmul_ok;
endmodule

// File: rtl/vl_cfg_vlmax.sv
module vl_cfg_vlmax
  import vl_cfg_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned VL_W = $clog2(VLEN + 1)
) (
  input  logic [SEL_W-1:0] sew_sel_i,
  input  logic [SEL_W-1:0] lmul_sel_i,
  output logic [VL_W-1:0]  vlmax_o
);
  localparam int unsigned BASE = VLEN / MIN_SEW_BITS;
  logic [VL_W-1:0] grown;

  // grow by group first, then shrink by width: stays exact, shifts only
  assign grown   = VL_W'(BASE) << lmul_sel_i[LMUL_IDX_W-1:0];
  assign vlmax_o = grown >> sew_sel_i[LMUL_IDX_W-1:0];
endmodule

// File: rtl/vl_cfg_align.sv
module vl_cfg_align
  import vl_cfg_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [SEL_W-1:0] lmul_sel_i,
  input  logic [REG_W-1:0] reg_idx_i,
  output logic             ok_o
);
  localparam int unsigned NG = LMUL_SEL_MAX + 1;
  logic [NG-1:0] ok_vec;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam logic [REG_W-1:0] LOW_MASK = REG_W'((1 << g) - 1);
    assign ok_vec[g] = ((reg_idx_i & LOW_MASK) == '0);
  end

  assign ok_o = ok_vec[lmul_sel_i[LMUL_IDX_W-1:0]];
endmodule

// File: rtl/vl_cfg_unit.sv
module vl_cfg_unit
  import vl_cfg_pkg::*;
#(
  parameter int unsigned VLEN      = 128,
  parameter int unsigned AVL_W     = 16,
  parameter int unsigned NUM_VREGS = 32,
  parameter int unsigned VL_W      = $clog2(VLEN + 1),
  parameter int unsigned REG_W     = $clog2(NUM_VREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [AVL_W-1:0] avl_i,
  input  logic [2:0]       sew_sel_i,
  input  logic [2:0]       lmul_sel_i,
  input  logic             tail_agn_i,
  input  logic             mask_agn_i,
  input  logic [REG_W-1:0] reg_idx_i,
  output logic             done_o,
  output logic             illegal_o,
  output logic [VL_W-1:0]  vl_o,
  output logic [VL_W-1:0]  vlmax_o,
  output logic [2:0]       cur_sew_o,
  output logic [2:0]       cur_lmul_o,
  output logic             cur_tail_agn_o,
  output logic             cur_mask_agn_o,
  output logic             reg_ok_o
);
  localparam int unsigned CMP_W = (AVL_W > VL_W) ? AVL_W : VL_W;
  localparam vcfg_t CFG_RST = '{sew: '0, lmul: '0, tail_agn: 1'b0, mask_agn: 1'b0};

  vcfg_t           cfg_q;
  logic            done_q, illegal_q;
  logic [VL_W-1:0] vl_q;
  logic            req_legal;
  logic [VL_W-1:0] req_vlmax, grant;
  logic [CMP_W-1:0] avl_x, lim_x;

  vl_cfg_decode u_dec (
    .sew_sel_i (sew_sel_i),
    .lmul_sel_i(lmul_sel_i),
    .legal_o   (req_legal)
  );

  vl_cfg_vlmax #(.VLEN(VLEN), .VL_W(VL_W)) u_req_max (
    .sew_sel_i (sew_sel_i),
    .lmul_sel_i(lmul_sel_i),
    .vlmax_o   (req_vlmax)
  );

  vl_cfg_vlmax #(.VLEN(VLEN), .VL_W(VL_W)) u_cur_max (
    .sew_sel_i (cfg_q.sew),
    .lmul_sel_i(cfg_q.lmul),
    .vlmax_o   (vlmax_o)
  );

  vl_cfg_align #(.REG_W(REG_W)) u_align (
    .lmul_sel_i(cfg_q.lmul),
    .reg_idx_i (reg_idx_i),
    .ok_o      (reg_ok_o)
  );

  assign avl_x = CMP_W'(avl_i);
  assign lim_x = CMP_W'(req_vlmax);
  assign grant = (avl_x >= lim_x) ? req_vlmax : VL_W'(avl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= CFG_RST;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      vl_q      <= '0;
    end else begin
      done_q <= req_i;
      if (req_i) begin
        illegal_q <= ~req_legal;
        vl_q      <= req_legal ? grant : '0;
        if (req_legal) begin
          cfg_q.sew      <= sew_sel_i;
          cfg_q.lmul     <= lmul_sel_i;
          cfg_q.tail_agn <= tail_agn_i;
          cfg_q.mask_agn <= mask_agn_i;
        end
      end
    end
  end

  assign done_o         = done_q;
  assign illegal_o      = illegal_q;
  assign vl_o           = vl_q;
  assign cur_sew_o      = cfg_q.sew;
  assign cur_lmul_o     = cfg_q.lmul;
  assign cur_tail_agn_o = cfg_q.tail_agn;
  assign cur_mask_agn_o = cfg_q.mask_agn;
endmodule

// File: rtl/vl_cfg_chk.sv
module vl_cfg_chk #(
  parameter int unsigned AVL_W = 16,
  parameter int unsigned VL_W  = 8,
  parameter int unsigned REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [AVL_W-1:0] avl_i,
  input logic [2:0]       sew_sel_i,
  input logic [2:0]       lmul_sel_i,
  input logic [REG_W-1:0] reg_idx_i,
  input logic             done_o,
  input logic             illegal_o,
  input logic [VL_W-1:0]  vl_o,
  input logic [VL_W-1:0]  vlmax_o,
  input logic [2:0]       cur_sew_o,
  input logic [2:0]       cur_lmul_o,
  input logic             cur_tail_agn_o,
  input logic             cur_mask_agn_o,
  input logic             reg_ok_o
);
  logic bad_sel;
  assign bad_sel = sew_sel_i[2] | lmul_sel_i[2];

  // R6
  done_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);
  // R6
  done_only_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !done_o && $stable(vl_o) && $stable(illegal_o));
  // R3
  illegal_zero_vl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && bad_sel |=> illegal_o && vl_o == '0);
  // R4
  illegal_keeps_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && bad_sel |=> $stable(cur_sew_o) && $stable(cur_lmul_o)
      && $stable(cur_tail_agn_o) && $stable(cur_mask_agn_o) && $stable(vlmax_o));
  // R2
  vl_within_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !illegal_o |-> vl_o <= vlmax_o);
  // R2
  zero_avl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && avl_i == '0 |=> vl_o == '0);
  // R5
  legal_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !bad_sel |=> !illegal_o && cur_lmul_o == $past(lmul_sel_i)
      && cur_sew_o == $past(sew_sel_i));
  // R7
  group8_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_lmul_o == 3'd3 && reg_idx_i[2:0] != 3'd0 |-> !reg_ok_o);
  // R7
  group1_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_lmul_o == 3'd0 |-> reg_ok_o);
endmodule

bind vl_cfg_unit vl_cfg_chk #(.AVL_W(AVL_W), .VL_W(VL_W), .REG_W(REG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .avl_i(avl_i),
  .sew_sel_i(sew_sel_i), .lmul_sel_i(lmul_sel_i), .reg_idx_i(reg_idx_i),
  .done_o(done_o), .illegal_o(illegal_o), .vl_o(vl_o), .vlmax_o(vlmax_o),
  .cur_sew_o(cur_sew_o), .cur_lmul_o(cur_lmul_o),
  .cur_tail_agn_o(cur_tail_agn_o), .cur_mask_agn_o(cur_mask_agn_o),
  .reg_ok_o(reg_ok_o)
);

// File: tb/sim_vl_cfg_unit.sv
module sim_vl_cfg_unit;
  localparam int unsigned VLEN  = 128;
  localparam int unsigned AVL_W = 16;
  localparam int unsigned VL_W  = $clog2(VLEN + 1);
  localparam int unsigned REG_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, ta = 1'b0, ma = 1'b0;
  logic [AVL_W-1:0] avl = '0;
  logic [2:0] sew = '0, lmul = '0;
  logic [REG_W-1:0] ridx = '0;
  logic done, illegal, cta, cma, rok;
  logic [VL_W-1:0] vl, vmax;
  logic [2:0] csew, clmul;

  int errors = 0, checks = 0;
  bit finished = 0;
  // model of the active configuration
  int m_sew = 0, m_lmul = 0, m_ta = 0, m_ma = 0;

  always #4 clk = ~clk;

  vl_cfg_unit #(.VLEN(VLEN), .AVL_W(AVL_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .avl_i(avl),
    .sew_sel_i(sew), .lmul_sel_i(lmul), .tail_agn_i(ta), .mask_agn_i(ma),
    .reg_idx_i(ridx), .done_o(done), .illegal_o(illegal), .vl_o(vl),
    .vlmax_o(vmax), .cur_sew_o(csew), .cur_lmul_o(clmul),
    .cur_tail_agn_o(cta), .cur_mask_agn_o(cma), .reg_ok_o(rok)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lim(input int s, input int l);
    return (VLEN / (8 << s)) * (1 << l);
  endfunction

  task automatic check_cfg(input string tag);
    check({tag, " sew"}, csew, m_sew);
    check({tag, " lmul"}, clmul, m_lmul);
    check({tag, " ta"}, cta, m_ta);
    check({tag, " ma"}, cma, m_ma);
    check({tag, " vlmax"}, vmax, lim(m_sew, m_lmul));
  endtask

  task automatic issue(input int a, input int s, input int l, input bit t, input bit m);
    bit ok;
    int ev;
    @(negedge clk);
    req = 1'b1; avl = AVL_W'(a); sew = 3'(s); lmul = 3'(l); ta = t; ma = m;
    @(negedge clk);
    req = 1'b0;
    ok = (s <= 3) && (l <= 3);
    ev = ok ? ((a >= lim(s, l)) ? lim(s, l) : a) : 0;
    if (ok) begin m_sew = s; m_lmul = l; m_ta = t; m_ma = m; end
    check("R6 done pulse", done, 1);
    check("R3 illegal flag", illegal, !ok);
    check(ok ? "R2 granted vl" : "R3 illegal vl", vl, ev);
    check(ok ? "R5 stored cfg" : "R4 cfg kept", {csew, clmul, cta, cma},
          {3'(m_sew), 3'(m_lmul), 1'(m_ta), 1'(m_ma)});
    check("R1 vlmax", vmax, lim(m_sew, m_lmul));
    @(negedge clk);
    check("R6 done low", done, 0);
    check("R6 vl held", vl, ev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 done", done, 0);
    check("R8 illegal", illegal, 0);
    check("R8 vl", vl, 0);
    check_cfg("R8");
    check("R8 vlmax e8", vmax, VLEN / 8);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5: all codes, several request sizes
    for (int s = 0; s < 8; s++)
      for (int l = 0; l < 8; l++)
        for (int k = 0; k < 6; k++) begin
          int lm, a;
          lm = lim(s & 3, l & 3);
          case (k)
            0: a = 0;
            1: a = 1;
            2: a = lm - 1;
            3: a = lm;
            4: a = lm + 1;
            default: a = (1 << AVL_W) - 1;
          endcase
          issue(a, s, l, bit'((s + k) & 1), bit'((l + k) >> 1 & 1));
        end

    // R1 known points: e32 at groups 1, 4, 8
    issue(100, 2, 0, 0, 0); check("R1 e32 m1", vl, 4);
    issue(100, 2, 2, 1, 1); check("R1 e32 m4", vl, 16);
    issue(3, 2, 3, 0, 1);   check("R2 below limit", vl, 3);
    issue(100, 2, 3, 1, 0); check("R1 e32 m8", vl, 32);

    // R4 illegal request after a legal one leaves everything
    issue(5, 7, 1, 1, 1);
    check_cfg("R4 after illegal");

    // R7 register alignment for each group size
    for (int l = 0; l < 4; l++) begin
      issue(1, 1, l, 0, 0);
      for (int r = 0; r < 32; r++) begin
        @(negedge clk);
        ridx = REG_W'(r);
        #1;
        check("R7 reg base", rok, (r % (1 << l)) == 0);
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule